// File: doc/BRIEF.md
# Multi-Flag Doorbell Mailbox

This block carries event notifications from a sender to a receiver over a configurable number of doorbell channels. Each channel holds a 32-bit word of pending flags, and every flag is a separate one-bit event. The sender can raise several events at once on one channel by writing more than one 1 bit. The receiver sees a level interrupt for each channel that has an unmasked pending flag. It reads the pending word and clears the flags it has handled. A clear of a flag that was pending is reflected back to the sender. It is held there as a sticky acknowledge status bit, which can raise a per-channel acknowledge interrupt.

Each side has its own simple register port, made of valid, write, word address and write data, with read data returned combinationally in the same cycle. A word address is `{channel, register}`, where the register field is the two low bits. The channel field is wide enough to hold at least one code above the last channel. Each side also has one combined interrupt, which is the OR of its per-channel interrupts.

Top module: `db_mailbox`

## Requirements
- R1: After reset, every pending, mask, acknowledge-status and acknowledge-enable bit is 0, and all interrupts are low.
- R2: A sender write to register 0 sets each flag written as 1 and leaves every flag written as 0 unchanged. Setting a flag that is already pending merges into the one pending event, so a single clear removes it.
- R3: A read of register 0 returns the channel's pending flags in the same cycle, on the sender port and on the receiver port alike.
- R4: A receiver write to register 1 clears each flag written as 1 and leaves the rest unchanged. A receiver read of register 1 returns 0.
- R5: The receiver mask is register 2 on the receiver port, and a mask bit of 1 hides that flag. `rx_irq[c]` is high while channel c has a pending flag whose mask bit is 0, and `rx_irq_any` is the OR of all `rx_irq` bits.
- R6: A receiver clear of a flag that was pending sets that flag's acknowledge-status bit. A clear of a flag that was not pending sets no status bit. The status is read at sender register 1.
- R7: An acknowledge-status bit stays set until the sender writes 1 to it at register 1. The acknowledge enable is sender register 2, read/write. `ack_irq[c]` is high while a status bit with its enable bit set is present, and `ack_irq_any` is the OR of all `ack_irq` bits.
- R8: When the sender sets and the receiver clears the same flag in one cycle, the flag stays pending. An acknowledge is recorded only if the flag was already pending before that cycle.
- R9: When a new acknowledge and a sender write-1 to the same status bit fall in one cycle, the status bit stays set.
- R10: Register 3 on either port reads the implemented channel count, whatever the channel field holds. Writes to register 3 have no effect.
- R11: An access whose channel field is at or above the channel count changes no state, and a read from it returns 0 for registers 0 to 2.
- R12: Channels are independent: an access to one channel changes no other channel's flags, status or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_valid | input | 1 | Sender port access strobe |
| tx_write | input | 1 | Sender access is a write |
| tx_addr | input | ADDR_W | Sender word address {channel, register} |
| tx_wdata | input | 32 | Sender write data |
| tx_rdata | output | 32 | Sender read data (same cycle) |
| rx_valid | input | 1 | Receiver port access strobe |
| rx_write | input | 1 | Receiver access is a write |
| rx_addr | input | ADDR_W | Receiver word address {channel, register} |
| rx_wdata | input | 32 | Receiver write data |
| rx_rdata | output | 32 | Receiver read data (same cycle) |
| rx_irq | output | NUM_CH | Per-channel transfer interrupt, level |
| rx_irq_any | output | 1 | Combined receiver interrupt |
| ack_irq | output | NUM_CH | Per-channel acknowledge interrupt, level |
| ack_irq_any | output | 1 | Combined sender interrupt |

## Verification
Two pairs of functions can fall in the same cycle, because the two ports are independent.

The first pair is a sender set and a receiver clear of the same flag. The bench provokes it by driving both ports before one clock edge, using a word in which one flag was already pending and one was not. It then judges the result by reading back the pending word and the acknowledge status: the flag stays set in both cases, and only the previously pending flag is acknowledged.

The second pair is a fresh acknowledge and a sender write-1 to the same status bit. The bench provokes it by issuing the receiver clear and the status clear together. It then checks that the status bit survives that cycle.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int FLAG_W = 32;

    typedef logic [FLAG_W-1:0] flag_t;

    // Per-channel register state
    typedef struct packed {
        flag_t pend;   // pending events
        flag_t mask;   // receiver mask (1 hides)
        flag_t ack;    // sticky acknowledge status
        flag_t acken;  // acknowledge interrupt enable
    } chan_state_t;

    // Register index, low two address bits
    typedef enum logic [1:0] {
        TX_SET        = 2'd0,
        TX_ACK_STATUS = 2'd1,
        TX_ACK_ENABLE = 2'd2,
        TX_INFO       = 2'd3
    } tx_reg_e;

    typedef enum logic [1:0] {
        RX_PENDING = 2'd0,
        RX_CLEAR   = 2'd1,
        RX_MASK    = 2'd2,
        RX_INFO    = 2'd3
    } rx_reg_e;

endpackage

// File: rtl/db_port_decode.sv
module db_port_decode #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic [CH_W+1:0]   addr,
    output logic [CH_W-1:0]   ch,
    output logic [1:0]        rg,
    output logic              in_range,
    output logic [NUM_CH-1:0] we_r0,
    output logic [NUM_CH-1:0] we_r1,
    output logic [NUM_CH-1:0] we_r2
);

    always_comb begin
        ch       = addr[CH_W+1:2];
        rg       = addr[1:0];
        in_range = (ch < CH_W'(NUM_CH));
        we_r0    = '0;
        we_r1    = '0;
        we_r2    = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (valid && write && in_range && ch == CH_W'(i)) begin
                we_r0[i] = (rg == 2'd0);
                we_r1[i] = (rg == 2'd1);
                we_r2[i] = (rg == 2'd2);
            end
        end
    end

    // R11: a channel field past the last channel strobes nothing
    assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && (addr[CH_W+1:2] >= CH_W'(NUM_CH))) |-> ((we_r0 | we_r1 | we_r2) == '0));

    // R12: at most one channel is written per access
    assert_single_channel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_r0 | we_r1 | we_r2));

    // R10: the count register is never written
    assert_info_read_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] == 2'd3) |-> ((we_r0 | we_r1 | we_r2) == '0));

endmodule

// File: rtl/db_channel.sv
module db_channel
    import db_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  flag_t tx_wdata,
    input  flag_t rx_wdata,
    input  logic  set_we,
    input  logic  ackclr_we,
    input  logic  acken_we,
    input  logic  clr_we,
    input  logic  mask_we,
    output flag_t pend,
    output flag_t mask,
    output flag_t ack,
    output flag_t acken,
    output logic  rx_irq,
    output logic  ack_irq
);

    chan_state_t state_d, state_q;
    flag_t       set_bits, clr_bits, ack_pulse, ackclr_bits;

    always_comb begin
        set_bits    = set_we    ? tx_wdata : '0;
        clr_bits    = clr_we    ? rx_wdata : '0;
        ackclr_bits = ackclr_we ? tx_wdata : '0;
        // a flag consumed by the receiver while it was pending
        ack_pulse   = state_q.pend & clr_bits;

        state_d       = state_q;
        // set wins over a clear in the same cycle
        state_d.pend  = (state_q.pend & ~clr_bits) | set_bits;
        // a fresh acknowledge wins over a status clear
        state_d.ack   = (state_q.ack & ~ackclr_bits) | ack_pulse;
        if (mask_we)  state_d.mask  = rx_wdata;
        if (acken_we) state_d.acken = tx_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pend    = state_q.pend;
    assign mask    = state_q.mask;
    assign ack     = state_q.ack;
    assign acken   = state_q.acken;
    assign rx_irq  = |(state_q.pend & ~state_q.mask);
    assign ack_irq = |(state_q.ack & state_q.acken);

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((state_q.pend & $past(tx_wdata)) == $past(tx_wdata)));

    assert_pend_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(state_q.pend));

    assert_clear_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((state_q.pend & $past(rx_wdata)) == '0));

    assert_idle_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pend == '0) |-> !rx_irq);

    assert_ack_on_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((state_q.ack & $past(state_q.pend & rx_wdata)) == $past(state_q.pend & rx_wdata)));

    assert_ack_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ackclr_we |=> ((state_q.ack & $past(state_q.ack)) == $past(state_q.ack)));

endmodule

// File: rtl/db_mailbox.sv
module db_mailbox
    import db_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int CH_W   = $clog2(NUM_CH + 1),
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic              tx_write,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [31:0]       tx_wdata,
    output logic [31:0]       tx_rdata,
    input  logic              rx_valid,
    input  logic              rx_write,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [31:0]       rx_wdata,
    output logic [31:0]       rx_rdata,
    output logic [NUM_CH-1:0] rx_irq,
    output logic              rx_irq_any,
    output logic [NUM_CH-1:0] ack_irq,
    output logic              ack_irq_any
);

    logic [CH_W-1:0]   tx_ch, rx_ch;
    logic [1:0]        tx_rg, rx_rg;
    logic              tx_in, rx_in;
    logic [NUM_CH-1:0] tx_we0, tx_we1, tx_we2;
    logic [NUM_CH-1:0] rx_we0, rx_we1, rx_we2;

    flag_t pend_w  [NUM_CH];
    flag_t mask_w  [NUM_CH];
    flag_t ack_w   [NUM_CH];
    flag_t acken_w [NUM_CH];

    db_port_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_tx_dec (
        .clk(clk), .rst_n(rst_n), .valid(tx_valid), .write(tx_write), .addr(tx_addr),
        .ch(tx_ch), .rg(tx_rg), .in_range(tx_in),
        .we_r0(tx_we0), .we_r1(tx_we1), .we_r2(tx_we2)
    );

    db_port_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_rx_dec (
        .clk(clk), .rst_n(rst_n), .valid(rx_valid), .write(rx_write), .addr(rx_addr),
        .ch(rx_ch), .rg(rx_rg), .in_range(rx_in),
        .we_r0(rx_we0), .we_r1(rx_we1), .we_r2(rx_we2)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        db_channel i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tx_wdata  (tx_wdata),
            .rx_wdata  (rx_wdata),
            .set_we    (tx_we0[c]),
            .ackclr_we (tx_we1[c]),
            .acken_we  (tx_we2[c]),
            .clr_we    (rx_we1[c]),
            .mask_we   (rx_we2[c]),
            .pend      (pend_w[c]),
            .mask      (mask_w[c]),
            .ack       (ack_w[c]),
            .acken     (acken_w[c]),
            .rx_irq    (rx_irq[c]),
            .ack_irq   (ack_irq[c])
        );
    end

    // receiver register 0 writes are not defined; the strobe stays unused
    logic unused_rx_we0;
    assign unused_rx_we0 = |rx_we0;

    always_comb begin
        tx_rdata = '0;
        if (tx_rg == TX_INFO) begin
            tx_rdata = FLAG_W'(NUM_CH);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (tx_in && tx_ch == CH_W'(i)) begin
                    case (tx_rg)
                        TX_SET:        tx_rdata = pend_w[i];
                        TX_ACK_STATUS: tx_rdata = ack_w[i];
                        TX_ACK_ENABLE: tx_rdata = acken_w[i];
                        default:       tx_rdata = '0;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rx_rdata = '0;
        if (rx_rg == RX_INFO) begin
            rx_rdata = FLAG_W'(NUM_CH);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (rx_in && rx_ch == CH_W'(i)) begin
                    case (rx_rg)
                        RX_PENDING: rx_rdata = pend_w[i];
                        RX_MASK:    rx_rdata = mask_w[i];
                        default:    rx_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign rx_irq_any  = |rx_irq;
    assign ack_irq_any = |ack_irq;

    // R5: combined line never high without a channel line
    assert_combined_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_any |-> ($countones(rx_irq) > 0));

    // R7: combined acknowledge line follows the channel lines
    assert_combined_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_irq == '0) |-> !ack_irq_any);

endmodule

// File: tb/test_db_mailbox.sv
module test_db_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int ADDR_W     = 5;

    typedef struct packed {
        logic [3:0]  req;
        logic        rx;      // 1 = receiver port
        logic        wr;
        logic [4:0]  addr;    // {channel[2:0], register[1:0]}
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [3:0]  exp_rxirq;
        logic [3:0]  exp_ackirq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd10, 1'b1, 1'b0, {3'd0, 2'd3}, 32'h0,         32'd4,         4'h0, 4'h0}, // R10
        '{4'd10, 1'b0, 1'b0, {3'd6, 2'd3}, 32'h0,         32'd4,         4'h0, 4'h0}, // R10
        '{4'd2,  1'b0, 1'b1, {3'd0, 2'd0}, 32'h5,         32'h0,         4'h1, 4'h0}, // R2
        '{4'd2,  1'b0, 1'b1, {3'd0, 2'd0}, 32'h1,         32'h0,         4'h1, 4'h0}, // R2
        '{4'd3,  1'b1, 1'b0, {3'd0, 2'd0}, 32'h0,         32'h5,         4'h1, 4'h0}, // R3
        '{4'd7,  1'b0, 1'b1, {3'd0, 2'd2}, 32'hFFFF_FFFF, 32'h0,         4'h1, 4'h0}, // R7
        '{4'd6,  1'b1, 1'b1, {3'd0, 2'd1}, 32'h3,         32'h0,         4'h1, 4'h1}, // R6
        '{4'd6,  1'b0, 1'b0, {3'd0, 2'd1}, 32'h0,         32'h1,         4'h1, 4'h1}, // R6
        '{4'd4,  1'b1, 1'b0, {3'd0, 2'd0}, 32'h0,         32'h4,         4'h1, 4'h1}, // R4
        '{4'd5,  1'b1, 1'b1, {3'd0, 2'd2}, 32'h4,         32'h0,         4'h0, 4'h1}, // R5
        '{4'd5,  1'b1, 1'b0, {3'd0, 2'd2}, 32'h0,         32'h4,         4'h0, 4'h1}, // R5
        '{4'd7,  1'b0, 1'b1, {3'd0, 2'd1}, 32'h1,         32'h0,         4'h0, 4'h0}, // R7
        '{4'd7,  1'b0, 1'b0, {3'd0, 2'd1}, 32'h0,         32'h0,         4'h0, 4'h0}, // R7
        '{4'd12, 1'b0, 1'b1, {3'd2, 2'd0}, 32'h8000_0000, 32'h0,         4'h4, 4'h0}, // R12
        '{4'd7,  1'b1, 1'b1, {3'd2, 2'd1}, 32'h8000_0000, 32'h0,         4'h0, 4'h0}, // R7
        '{4'd6,  1'b0, 1'b0, {3'd2, 2'd1}, 32'h0,         32'h8000_0000, 4'h0, 4'h0}, // R6
        '{4'd7,  1'b0, 1'b1, {3'd2, 2'd2}, 32'h8000_0000, 32'h0,         4'h0, 4'h4}, // R7
        '{4'd11, 1'b0, 1'b1, {3'd5, 2'd0}, 32'hFFFF_FFFF, 32'h0,         4'h0, 4'h4}, // R11
        '{4'd11, 1'b1, 1'b0, {3'd5, 2'd0}, 32'h0,         32'h0,         4'h0, 4'h4}, // R11
        '{4'd10, 1'b0, 1'b1, {3'd0, 2'd3}, 32'h0,         32'h0,         4'h0, 4'h4}, // R10
        '{4'd10, 1'b0, 1'b0, {3'd0, 2'd3}, 32'h0,         32'd4,         4'h0, 4'h4}, // R10
        '{4'd6,  1'b1, 1'b1, {3'd1, 2'd1}, 32'hFFFF_FFFF, 32'h0,         4'h0, 4'h4}, // R6
        '{4'd6,  1'b0, 1'b0, {3'd1, 2'd1}, 32'h0,         32'h0,         4'h0, 4'h4}  // R6
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_valid = 1'b0, tx_write = 1'b0;
    logic [ADDR_W-1:0] tx_addr = '0;
    logic [31:0]       tx_wdata = '0;
    logic [31:0]       tx_rdata;
    logic              rx_valid = 1'b0, rx_write = 1'b0;
    logic [ADDR_W-1:0] rx_addr = '0;
    logic [31:0]       rx_wdata = '0;
    logic [31:0]       rx_rdata;
    logic [NUM_CH-1:0] rx_irq, ack_irq;
    logic              rx_irq_any, ack_irq_any;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    db_mailbox #(.NUM_CH(NUM_CH)) i_db_mailbox (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_write(tx_write), .tx_addr(tx_addr),
        .tx_wdata(tx_wdata), .tx_rdata(tx_rdata),
        .rx_valid(rx_valid), .rx_write(rx_write), .rx_addr(rx_addr),
        .rx_wdata(rx_wdata), .rx_rdata(rx_rdata),
        .rx_irq(rx_irq), .rx_irq_any(rx_irq_any),
        .ack_irq(ack_irq), .ack_irq_any(ack_irq_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // irq word: {rx_any, ack_any, rx_irq, ack_irq}
    function automatic logic [31:0] irq_word(input logic [3:0] r, input logic [3:0] a);
        return {22'd0, |r, |a, r, a};
    endfunction

    task automatic tx_op(input logic wr, input logic [4:0] a, input logic [31:0] d);
        tx_valid = 1'b1; tx_write = wr; tx_addr = a; tx_wdata = d;
    endtask

    task automatic rx_op(input logic wr, input logic [4:0] a, input logic [31:0] d);
        rx_valid = 1'b1; rx_write = wr; rx_addr = a; rx_wdata = d;
    endtask

    task automatic idle();
        tx_valid = 1'b0; tx_write = 1'b0; rx_valid = 1'b0; rx_write = 1'b0;
    endtask

    task automatic tx_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); tx_op(1'b0, a, 32'h0); #1 d = tx_rdata; idle();
    endtask

    task automatic rx_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); rx_op(1'b0, a, 32'h0); #1 d = rx_rdata; idle();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reset_state_checks(input string tag);
        logic [31:0] v;
        check(tag, irq_word(rx_irq, ack_irq), 32'h0);
        for (int c = 0; c < NUM_CH; c++) begin
            tx_read({c[2:0], 2'd0}, v); check(tag, v, 32'h0);
            tx_read({c[2:0], 2'd1}, v); check(tag, v, 32'h0);
            tx_read({c[2:0], 2'd2}, v); check(tag, v, 32'h0);
            rx_read({c[2:0], 2'd2}, v); check(tag, v, 32'h0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        string       tag;
        do_reset();
        @(negedge clk);
        reset_state_checks("R1 reset state");

        // table walk
        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
            @(negedge clk);
            if (VECS[i].rx) rx_op(VECS[i].wr, VECS[i].addr, VECS[i].data);
            else            tx_op(VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr) begin
                #1;
                check(tag, VECS[i].rx ? rx_rdata : tx_rdata, VECS[i].exp_rd);
            end
            @(posedge clk); #1;
            idle();
            check(tag, irq_word(rx_irq, ack_irq), irq_word(VECS[i].exp_rxirq, VECS[i].exp_ackirq));
        end

        // R8: set and clear of the same flags in one cycle, bit0 already pending
        @(negedge clk); tx_op(1'b1, {3'd3, 2'd0}, 32'h1);
        @(negedge clk); idle();
        @(negedge clk);
        tx_op(1'b1, {3'd3, 2'd0}, 32'h3);
        rx_op(1'b1, {3'd3, 2'd1}, 32'h3);
        @(negedge clk); idle();
        rx_read({3'd3, 2'd0}, v); check("R8 pending after set+clear", v, 32'h3);
        tx_read({3'd3, 2'd1}, v); check("R8 ack only for prior pending", v, 32'h1);

        // R9: new acknowledge and status clear of bit0 in one cycle
        @(negedge clk);
        rx_op(1'b1, {3'd3, 2'd1}, 32'h1);
        tx_op(1'b1, {3'd3, 2'd1}, 32'h1);
        @(negedge clk); idle();
        tx_read({3'd3, 2'd1}, v); check("R9 ack survives clear", v, 32'h1);
        rx_read({3'd3, 2'd0}, v); check("R4 bit0 cleared", v, 32'h2);
        rx_read({3'd3, 2'd1}, v); check("R4 clear register reads 0", v, 32'h0);
        // status clear alone now removes it
        @(negedge clk); tx_op(1'b1, {3'd3, 2'd1}, 32'h1);
        @(negedge clk); idle();
        tx_read({3'd3, 2'd1}, v); check("R7 status cleared by write-1", v, 32'h0);

        // R12: channel 3 activity left channel 2 untouched
        tx_read({3'd2, 2'd1}, v); check("R12 channel 2 status kept", v, 32'h8000_0000);
        #1 check("R5 channel 3 irq with pending flag", irq_word(rx_irq, ack_irq), irq_word(4'h8, 4'h4));

        // R1: reset from a busy state
        do_reset();
        @(negedge clk);
        reset_state_checks("R1 reset from busy state");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule